// File: doc/BRIEF.md
# Split-converter DAC error calibration engine

This block runs digital background calibration for a converter built as two parallel halves, A and B. Each half has a 4-bit first stage and a backend. Both halves digitise the same input. For every sample, the block takes each half's first-stage code and backend word and forms a raw result. It then adds a per-half correction that is the running sum of learned per-level DAC errors up to that half's stage code. Half B is also scaled by an adaptive gain coefficient. The block outputs the mean of the two corrected results as an 11-bit code.

Learning is driven by the difference between the two corrected halves. Half A serves as the reference.

- When B's stage code is one level above A's, the difference refines B's error term for that level.
- When A is one level above B, it refines A's term for that level.
- When the codes are equal, it adapts the gain coefficient.

All estimates are first-order averages whose step sizes are powers of two, so each update is an arithmetic shift. A level that the input never excites keeps its value. The calibration enable travels with each sample. When it is low, that sample changes no state.

Top module: `split_cal_engine`

## Requirements
- R1: After reset, in_ready is 0 while the internal reset release is pending, then 1. out_valid is 0, every level error term is 0 and the gain coefficient is unity (4096 with 12 fraction bits). A first sample with equal codes therefore yields floor((rawA+rawB)/2).
- R2: A sample is taken on a clock edge where in_valid and in_ready are both 1. in_ready is then 0 until the result is out. out_valid is a one-cycle pulse in the third cycle after the accepting edge.
- R3: raw = code·2^BE_W + word (BE_W=7). Each corrected value is computed in units of 2^-6 output LSB and saturated to ACC_W bits:
  - yA = raw_A·64 + ΔA[1] + … + ΔA[codeA]
  - yB = floor(α·(raw_B·64 + ΔB[1] + … + ΔB[codeB]) / 4096)
- R4: out_code = floor(floor((yA+yB)/2)/64), clamped to the range 0 to 2047.
- R5: With d = sat(yA−yB), when codeB = codeA+1 and calibration is enabled, ΔB[codeB] increases by floor(d/2^MU_SH), with MU_SH=4.
- R6: When codeA = codeB+1 and calibration is enabled, ΔA[codeA] decreases by floor(d/2^MU_SH).
- R7: When the codes are equal and calibration is enabled, α increases by floor(d/2^A_SH).
- R8: Codes that differ by two or more levels change no state. Terms for levels that are not updated keep their values.
- R9: cal_en is captured with each accepted sample. A sample taken with cal_en=0 changes no error term and does not change α.
- R10: Error terms saturate at 16-bit signed limits, α saturates at 16-bit signed limits, and the output saturates at 0 and 2047.
- R11: Repeating the same adjacent-code pair with calibration enabled brings the output to within 1 LSB of half A's raw result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Enables learning for the sample being accepted |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| code_a | input | ST_W | Half A first-stage code |
| word_a | input | BE_W | Half A backend word |
| code_b | input | ST_W | Half B first-stage code |
| word_b | input | BE_W | Half B backend word |
| out_valid | output | 1 | Corrected code present |
| out_code | output | ST_W+BE_W | Calibrated mean output |

## Verification
The bench keeps the default 4-bit stage, 7-bit backend, 6 fraction bits and the level step shift of 4. This gives all sixteen level tables and the full 11-bit output range. It sets the gain step shift to 4, so α can be driven into its upper saturation limit within a few dozen equal-code samples. Repeated adjacent pairs make the low clamp of the output reachable. A pseudo-random sweep of near-adjacent codes with cal_en toggling exercises every update path against the bench's own arithmetic model.

// File: rtl/cal_pkg.sv
package cal_pkg;
  // Clamp a wide signed value into the signed range of w bits.
  function automatic logic signed [47:0] clamp_s(input logic signed [47:0] v, input int unsigned w);
    logic signed [47:0] hi;
    logic signed [47:0] lo;
    hi = (48'sd1 <<< (w - 1)) - 48'sd1;
    lo = -(48'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/cal_corr_table.sv
module cal_corr_table
  import cal_pkg::*;
#(
  parameter int CW    = 4,
  parameter int EW    = 16,
  parameter int DW    = 24,
  parameter int MU_SH = 4,
  localparam int NLEV = 1 << CW,
  localparam int SW   = EW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        rd_code,
  input  logic                 upd_en,
  input  logic [CW-1:0]        upd_idx,
  input  logic                 upd_neg,
  input  logic signed [DW-1:0] upd_err,
  output logic signed [SW-1:0] cum
);
  logic signed [EW-1:0] est_q [NLEV];
  logic signed [SW-1:0] pre   [NLEV];
  logic signed [47:0]   step;
  logic signed [47:0]   nxt;

  // next value of the addressed level term
  always_comb begin
    step = 48'(upd_err) >>> MU_SH;
    if (upd_neg) step = -step;
    nxt = clamp_s(48'(est_q[upd_idx]) + step, EW);
  end

  for (genvar k = 0; k < NLEV; k++) begin : g_lvl
    logic hit;
    assign hit = upd_en && (upd_idx == CW'(k)) && (k != 0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   est_q[k] <= '0;
      else if (hit) est_q[k] <= nxt[EW-1:0];
    end
    if (k == 0) begin : g_base
      assign pre[k] = '0;
    end else begin : g_acc
      assign pre[k] = pre[k-1] + SW'(est_q[k]);
    end
  end

  assign cum = pre[rd_code];
endmodule

// File: rtl/cal_gain.sv
module cal_gain
  import cal_pkg::*;
#(
  parameter int AW   = 16,
  parameter int AF   = 12,
  parameter int DW   = 24,
  parameter int A_SH = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] y_in,
  output logic signed [DW-1:0] y_out,
  input  logic                 upd_en,
  input  logic signed [DW-1:0] err,
  output logic signed [AW-1:0] alpha
);
  localparam logic signed [AW-1:0] UNITY = AW'(1 << AF);

  logic signed [47:0] prod;
  logic signed [47:0] ysat;
  logic signed [47:0] a_nxt;

  always_comb begin
    prod  = (48'(y_in) * 48'(alpha)) >>> AF;
    ysat  = clamp_s(prod, DW);
    y_out = ysat[DW-1:0];
    a_nxt = clamp_s(48'(alpha) + (48'(err) >>> A_SH), AW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alpha <= UNITY;
    else if (upd_en) alpha <= a_nxt[AW-1:0];
  end
endmodule

// File: rtl/cal_combine.sv
module cal_combine #(
  parameter int DW   = 24,
  parameter int FRAC = 6,
  parameter int OW   = 11
) (
  input  logic signed [DW-1:0] ya,
  input  logic signed [DW-1:0] yb,
  output logic [OW-1:0]        code
);
  localparam logic signed [DW:0] TOP = (DW+1)'((1 << OW) - 1);

  logic signed [DW:0] sum;
  logic signed [DW:0] m;

  always_comb begin
    sum = (DW+1)'(ya) + (DW+1)'(yb);
    m   = (sum >>> 1) >>> FRAC;
    if (m[DW])       code = '0;
    else if (m > TOP) code = '1;
    else             code = m[OW-1:0];
  end
endmodule

// File: rtl/split_cal_engine.sv
module split_cal_engine
  import cal_pkg::*;
#(
  parameter int ST_W  = 4,
  parameter int BE_W  = 7,
  parameter int FRAC  = 6,
  parameter int EW    = 16,
  parameter int ACC_W = 24,
  parameter int AW    = 16,
  parameter int AF    = 12,
  parameter int MU_SH = 4,
  parameter int A_SH  = 6,
  localparam int OUT_W = ST_W + BE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ST_W-1:0]  code_a,
  input  logic [BE_W-1:0]  word_a,
  input  logic [ST_W-1:0]  code_b,
  input  logic [BE_W-1:0]  word_b,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_code
);
  localparam int RAW_W = ST_W + BE_W;
  localparam int SW    = EW + ST_W;
  localparam logic [ST_W:0] STEP1 = (ST_W+1)'(1);

  // reset release synchroniser
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic                    accept;
  logic                    s1_v, s1_en;
  logic [ST_W-1:0]         s1_ca, s1_cb;
  logic [RAW_W-1:0]        s1_ra, s1_rb;
  logic                    s2_v, s2_en;
  logic [ST_W-1:0]         s2_ca, s2_cb;
  logic signed [ACC_W-1:0] s2_ya, s2_ybu;
  logic signed [SW-1:0]    cum_a, cum_b;
  logic signed [47:0]      ya_w, ybu_w, err_w;
  logic signed [ACC_W-1:0] ya_d, ybu_d, yb_s, err;
  logic [OUT_W-1:0]        code_d;
  logic                    upd_ok, adj_a, adj_b, same;
  logic signed [AW-1:0]    alpha_w;

  assign accept   = in_valid && in_ready;
  assign in_ready = srst_n && !(s1_v || s2_v);

  // next-state datapath
  always_comb begin
    ya_w  = clamp_s((48'($signed({1'b0, s1_ra})) <<< FRAC) + 48'(cum_a), ACC_W);
    ybu_w = clamp_s((48'($signed({1'b0, s1_rb})) <<< FRAC) + 48'(cum_b), ACC_W);
    ya_d  = ya_w[ACC_W-1:0];
    ybu_d = ybu_w[ACC_W-1:0];
    err_w = clamp_s(48'(s2_ya) - 48'(yb_s), ACC_W);
    err   = err_w[ACC_W-1:0];
    upd_ok = s2_v && s2_en;
    adj_b  = upd_ok && ({1'b0, s2_cb} == ({1'b0, s2_ca} + STEP1));
    adj_a  = upd_ok && ({1'b0, s2_ca} == ({1'b0, s2_cb} + STEP1));
    same   = upd_ok && (s2_ca == s2_cb);
  end

  // pipeline registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s1_v <= 1'b0; s1_en <= 1'b0; s1_ca <= '0; s1_cb <= '0; s1_ra <= '0; s1_rb <= '0;
      s2_v <= 1'b0; s2_en <= 1'b0; s2_ca <= '0; s2_cb <= '0; s2_ya <= '0; s2_ybu <= '0;
      out_valid <= 1'b0; out_code <= '0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_en <= cal_en;
        s1_ca <= code_a;
        s1_cb <= code_b;
        s1_ra <= {code_a, word_a};
        s1_rb <= {code_b, word_b};
      end
      s2_v <= s1_v;
      if (s1_v) begin
        s2_en  <= s1_en;
        s2_ca  <= s1_ca;
        s2_cb  <= s1_cb;
        s2_ya  <= ya_d;
        s2_ybu <= ybu_d;
      end
      out_valid <= s2_v;
      if (s2_v) out_code <= code_d;
    end
  end

  cal_corr_table #(.CW(ST_W), .EW(EW), .DW(ACC_W), .MU_SH(MU_SH)) u_tab_a (
    .clk(clk), .rst_n(srst_n), .rd_code(s1_ca), .upd_en(adj_a),
    .upd_idx(s2_ca), .upd_neg(1'b1), .upd_err(err), .cum(cum_a)
  );

  cal_corr_table #(.CW(ST_W), .EW(EW), .DW(ACC_W), .MU_SH(MU_SH)) u_tab_b (
    .clk(clk), .rst_n(srst_n), .rd_code(s1_cb), .upd_en(adj_b),
    .upd_idx(s2_cb), .upd_neg(1'b0), .upd_err(err), .cum(cum_b)
  );

  cal_gain #(.AW(AW), .AF(AF), .DW(ACC_W), .A_SH(A_SH)) u_gain (
    .clk(clk), .rst_n(srst_n), .y_in(s2_ybu), .y_out(yb_s),
    .upd_en(same), .err(err), .alpha(alpha_w)
  );

  cal_combine #(.DW(ACC_W), .FRAC(FRAC), .OW(OUT_W)) u_comb (
    .ya(s2_ya), .yb(yb_s), .code(code_d)
  );
endmodule

// File: rtl/split_cal_chk.sv
module split_cal_chk #(
  parameter int ST_W = 4,
  parameter int AW   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 s2_v,
  input logic                 s2_en,
  input logic [ST_W-1:0]      s2_ca,
  input logic [ST_W-1:0]      s2_cb,
  input logic signed [AW-1:0] alpha
);
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready); // R2
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |-> ##3 out_valid); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R2
  AST_FROZEN_GAIN: assert property (@(posedge clk) disable iff (!rst_n) (s2_v && !s2_en) |=> $stable(alpha)); // R9
  AST_GAIN_EQUAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (s2_v && (s2_ca != s2_cb)) |=> $stable(alpha)); // R8
  AST_GAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !s2_v |=> $stable(alpha)); // R7
endmodule

bind split_cal_engine split_cal_chk #(.ST_W(ST_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .s2_v(s2_v), .s2_en(s2_en), .s2_ca(s2_ca),
  .s2_cb(s2_cb), .alpha(alpha_w)
);

// File: tb/tb_split_cal_engine.sv
`timescale 1ns/1ps
module tb_split_cal_engine;
  localparam int BE = 7;
  localparam int FR = 6;
  localparam int MU = 4;
  localparam int ASH = 4;

  logic clk = 1'b0;
  logic rst_n, cal_en, in_valid, in_ready, out_valid;
  logic [3:0] code_a, code_b;
  logic [6:0] word_a, word_b;
  logic [10:0] out_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  longint ea[16];
  longint eb[16];
  longint al;

  always #4 clk = ~clk;

  split_cal_engine #(.A_SH(ASH)) dut (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .in_valid(in_valid), .in_ready(in_ready),
    .code_a(code_a), .word_a(word_a), .code_b(code_b), .word_b(word_b),
    .out_valid(out_valid), .out_code(out_code)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampw(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Behavioural model of one sample: returns expected code, updates state.
  function automatic longint model(input int ca, input int bea, input int cb, input int beb, input bit en);
    longint ya, ybu, yb, d, m, sa, sb;
    sa = 0; sb = 0;
    for (int j = 1; j <= ca; j++) sa += ea[j];
    for (int j = 1; j <= cb; j++) sb += eb[j];
    ya  = clampw(longint'(ca * 128 + bea) * 64 + sa, 24);
    ybu = clampw(longint'(cb * 128 + beb) * 64 + sb, 24);
    yb  = clampw((ybu * al) >>> 12, 24);
    m   = ((ya + yb) >>> 1) >>> FR;
    if (m < 0) m = 0;
    if (m > 2047) m = 2047;
    d = clampw(ya - yb, 24);
    if (en) begin
      if (cb == ca + 1)      eb[cb] = clampw(eb[cb] + (d >>> MU), 16);
      else if (ca == cb + 1) ea[ca] = clampw(ea[ca] - (d >>> MU), 16);
      else if (ca == cb)     al = clampw(al + (d >>> ASH), 16);
    end
    return m;
  endfunction

  // Called at a negedge; returns at the negedge where the result is visible.
  task automatic send(input int ca, input int bea, input int cb, input int beb,
                      input bit en, input string tag, output int got);
    longint exp;
    exp = model(ca, bea, cb, beb, en);
    code_a = 4'(ca); word_a = 7'(bea); code_b = 4'(cb); word_b = 7'(beb);
    cal_en = en; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R2 busy", longint'(in_ready), 0);
    chk(!out_valid, "R2 early", longint'(out_valid), 0);
    @(negedge clk);
    chk(!out_valid, "R2 early", longint'(out_valid), 0);
    @(negedge clk);
    chk(out_valid, "R2 valid", longint'(out_valid), 1);
    chk(in_ready, "R2 ready", longint'(in_ready), 1);
    chk(longint'(out_code) == exp, tag, longint'(out_code), exp);
    got = int'(out_code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g, p1, p2;
    logic [15:0] lf;
    for (int i = 0; i < 16; i++) begin ea[i] = 0; eb[i] = 0; end
    al = 4096;
    rst_n = 1'b0; cal_en = 1'b0; in_valid = 1'b0;
    code_a = '0; code_b = '0; word_a = '0; word_b = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready, "R1 ready held", longint'(in_ready), 0);
    @(negedge clk);
    @(negedge clk);
    chk(in_ready, "R1 ready after release", longint'(in_ready), 1);
    chk(!out_valid, "R1 idle", longint'(out_valid), 0);

    // R1: first equal-code sample is plain raw mean; R7 gain step follows
    send(3, 10, 3, 20, 1'b1, "R1 R3 R4", g);
    chk(g == 399, "R1 raw mean", g, 399);
    send(3, 10, 3, 20, 1'b0, "R7 R3", g);
    chk(g == 397, "R7 gain adapted", g, 397);

    // R9: disabled samples leave the output unchanged
    send(4, 100, 5, 0, 1'b0, "R9", p1);
    for (int i = 0; i < 5; i++) send(4, 100, 5, 0, 1'b0, "R9", g);
    send(4, 100, 5, 0, 1'b0, "R9", p2);
    chk(p1 == p2, "R9 frozen", p2, p1);

    // R8: far-apart codes change nothing
    send(3, 0, 3, 0, 1'b0, "R8", p1);
    send(2, 5, 7, 9, 1'b1, "R8", g);
    send(12, 5, 1, 9, 1'b1, "R8", g);
    send(3, 0, 3, 0, 1'b0, "R8", p2);
    chk(p1 == p2, "R8 untouched level", p2, p1);

    // R5 / R11: repeated adjacent pair converges toward half A
    for (int i = 0; i < 100; i++) send(4, 100, 5, 0, 1'b1, "R5", g);
    send(4, 100, 5, 0, 1'b0, "R11", g);
    chk(g >= 611 && g <= 613, "R11 converged", g, 612);

    // R6 then R5 on level 1, then low clamp R10
    for (int i = 0; i < 60; i++) send(1, 127, 0, 0, 1'b1, "R6", g);
    for (int i = 0; i < 60; i++) send(0, 0, 1, 127, 1'b1, "R5", g);
    send(1, 0, 1, 0, 1'b0, "R10", g);
    chk(g == 0, "R10 low clamp", g, 0);

    // R7 / R10: gain driven to its limit, output clamps high
    for (int i = 0; i < 80; i++) send(0, 127, 0, 1, 1'b1, "R7", g);
    chk(al == 32767, "R10 gain limit in model", al, 32767);
    send(15, 127, 15, 127, 1'b0, "R10", g);
    chk(g == 2047, "R10 high clamp", g, 2047);

    // mixed sweep, near-adjacent codes, enable toggling
    lf = 16'hACE1;
    for (int i = 0; i < 150; i++) begin
      int ca, cb, sel;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ca  = int'(lf[3:0]);
      sel = int'(lf[5:4]) % 3;
      cb  = ca + sel - 1;
      if (cb < 0) cb = 0;
      if (cb > 15) cb = 15;
      send(ca, int'(lf[12:6]), cb, int'({lf[8:6], lf[15:12]}), lf[9], "R3 R4 R5 R6 R7 sweep", g);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule